// File: doc/BRIEF.md
# Instruction Step Controller

This block sits next to an 8-bit processor with a two-phase bus clock and lets an operator advance a program one instruction per button press. It samples the processor's phase-two clock level, its opcode-fetch marker (`sync`) and a debounced step button. It drives the processor's ready input (`rdy`), which stalls the bus. The block runs on a fast system clock, and all of these signals are sampled as levels on that clock.

In run mode `rdy` stays high. In step mode the controller pulls `rdy` low during the phase-two-low half of a fetch cycle, so the processor stops on that opcode fetch. A fresh press of the button releases the processor for exactly one instruction. The controller then stops it again at the following fetch. `rdy` never falls while phase two is high, because a ready drop in that half can hang the processor.

Top module: `instr_step_ctrl`

## Requirements
- R1: While `rstN` is low and on the first clock after it, `rdy` is 1 and `halted` is 0.
- R2: On every clock edge where `stepMode` is sampled 0, `rdy` is 1 after that edge. Leaving step mode while halted raises `rdy` and clears `halted` on the next edge.
- R3: After `stepMode` is sampled 1 in run mode, the first edge that samples `sync`=1 with `ph2`=0 drops `rdy` on the following edge, with no press needed.
- R4: `rdy` only falls after an edge that sampled `ph2`=0 together with `sync`=1. It never falls after an edge that sampled `ph2`=1.
- R5: While halted in step mode, an edge that samples `stepReq`=1 after it was 0 on the previous edge raises `rdy` on the next edge. Without such a rising edge, `rdy` stays low.
- R6: After a release, the fetch cycle in progress is allowed to finish. A phase-two falling edge must be seen first. The controller then halts on the next `sync`-high, `ph2`-low sample. Keeping `stepReq` held at 1 does not release the processor again.
- R7: A rising edge of `stepReq` seen while not halted has no effect. The next halt still happens, and `rdy` then stays low until a later press.
- R8: `halted` is 1 exactly when `rdy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ph2 | input | 1 | Level of the processor's phase-two clock (1 = high half of the bus cycle) |
| sync | input | 1 | 1 during a bus cycle that fetches an opcode |
| stepReq | input | 1 | Debounced step button, 1 = pressed |
| stepMode | input | 1 | 1 = single-step mode, 0 = free run |
| rdy | output | 1 | Ready to the processor; 0 stalls the bus |
| halted | output | 1 | 1 while the processor is being held |

## Verification
Each result is due one system clock after the edge that sampled its cause. A release follows the edge that sees the new press. A return to run follows the edge that sees `stepMode` low. A halt follows the edge that sees `sync` high with `ph2` low while the halt is armed, and `halted` moves in the same cycle as `rdy`. The bench changes inputs on falling clock edges. It compares `rdy` and `halted` with a behavioural model at every following falling edge, so each expected value is read exactly one rising edge after its cause. A bus generator in the bench stalls its low phase while `rdy` is low, so every halt is tested against a processor that actually waits.

// File: rtl/stepctl_pkg.sv
package stepctl_pkg;

  typedef enum logic [1:0] {
    MODE_RUN     = 2'd0,
    MODE_STEP_GO = 2'd1,
    MODE_HALT    = 2'd2
  } stepState_t;

  typedef struct packed {
    logic rdyRaise;
    logic rdyDrop;
    logic armSet;
    logic armClr;
  } stepStrobe_t;

endpackage

// File: rtl/stepctl_datapath.sv
module stepctl_datapath
  import stepctl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ph2,
  input  logic        stepReq,
  input  stepStrobe_t strobe,
  output logic        rdy,
  output logic        armed,
  output logic        ph2Fall,
  output logic        stepPulse
);

  logic rdyQ;
  logic armedQ;
  logic stepPrev;
  logic ph2Prev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdyQ     <= 1'b1;
      armedQ   <= 1'b0;
      stepPrev <= 1'b0;
      ph2Prev  <= 1'b0;
    end else begin
      stepPrev <= stepReq;
      ph2Prev  <= ph2;
      if (strobe.rdyDrop)       rdyQ <= 1'b0;
      else if (strobe.rdyRaise) rdyQ <= 1'b1;
      if (strobe.armClr)        armedQ <= 1'b0;
      else if (strobe.armSet)   armedQ <= 1'b1;
    end
  end

  assign stepPulse = stepReq & ~stepPrev;
  assign ph2Fall   = ph2Prev & ~ph2;
  assign rdy       = rdyQ;
  assign armed     = armedQ;

  // R6: a drop only happens once the halt has been armed
  assert_drop_needs_arm_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdyDrop |-> armedQ);

endmodule

// File: rtl/stepctl_fsm.sv
module stepctl_fsm
  import stepctl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        stepMode,
  input  logic        sync,
  input  logic        ph2,
  input  logic        armed,
  input  logic        ph2Fall,
  input  logic        stepPulse,
  output stepStrobe_t strobe,
  output logic        halted
);

  stepState_t state;
  stepState_t stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= MODE_RUN;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    case (state)
      MODE_RUN: begin
        if (stepMode) begin
          stateNxt      = MODE_STEP_GO;
          strobe.armSet = 1'b1;
        end
      end
      MODE_STEP_GO: begin
        if (!stepMode) begin
          stateNxt = MODE_RUN;
        end else if (armed && sync && !ph2) begin
          stateNxt       = MODE_HALT;
          strobe.rdyDrop = 1'b1;
        end else if (ph2Fall) begin
          strobe.armSet = 1'b1;
        end
      end
      MODE_HALT: begin
        if (!stepMode) begin
          stateNxt        = MODE_RUN;
          strobe.rdyRaise = 1'b1;
        end else if (stepPulse) begin
          stateNxt        = MODE_STEP_GO;
          strobe.rdyRaise = 1'b1;
          strobe.armClr   = 1'b1;
        end
      end
      default: stateNxt = MODE_RUN;
    endcase
  end

  assign halted = (state == MODE_HALT);

  // R4: the halt state is entered only from a sampled fetch in the low phase
  assert_halt_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stateNxt == MODE_HALT && state != MODE_HALT) |-> (sync && !ph2));

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.rdyRaise && strobe.rdyDrop));

endmodule

// File: rtl/instr_step_ctrl.sv
module instr_step_ctrl
  import stepctl_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic ph2,
  input  logic sync,
  input  logic stepReq,
  input  logic stepMode,
  output logic rdy,
  output logic halted
);

  stepStrobe_t strobe;
  logic        armed;
  logic        ph2Fall;
  logic        stepPulse;

  stepctl_fsm uFsm (
    .clk       (clk),
    .rstN      (rstN),
    .stepMode  (stepMode),
    .sync      (sync),
    .ph2       (ph2),
    .armed     (armed),
    .ph2Fall   (ph2Fall),
    .stepPulse (stepPulse),
    .strobe    (strobe),
    .halted    (halted)
  );

  stepctl_datapath uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ph2       (ph2),
    .stepReq   (stepReq),
    .strobe    (strobe),
    .rdy       (rdy),
    .armed     (armed),
    .ph2Fall   (ph2Fall),
    .stepPulse (stepPulse)
  );

  assert_reset_state_R1: assert property (@(posedge clk)
    !rstN |=> (rdy && !halted));

  assert_run_mode_R2: assert property (@(posedge clk) disable iff (!rstN)
    !stepMode |=> rdy);

  assert_fall_in_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdy) |-> (!$past(ph2) && $past(sync)));

  assert_release_on_press_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rdy) && $past(stepMode)) |-> $past(stepPulse));

  assert_flag_matches_R8: assert property (@(posedge clk) disable iff (!rstN)
    halted == !rdy);

endmodule

// File: tb/instr_step_ctrl_test.sv
module instr_step_ctrl_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ph2 = 1'b0;
  logic sync = 1'b0;
  logic stepReq = 1'b0;
  logic stepMode = 1'b0;
  logic rdy;
  logic halted;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit started = 1'b0;
  string curReq = "R2";

  // behavioural reference
  int  mState = 0;   // 0 run, 1 stepping, 2 held
  bit  mRdy = 1'b1;
  bit  mArm = 1'b0;
  bit  mStepQ = 1'b0;
  bit  mPh2Q = 1'b0;

  always #2 clk = ~clk;

  instr_step_ctrl uut (
    .clk(clk), .rstN(rstN), .ph2(ph2), .sync(sync),
    .stepReq(stepReq), .stepMode(stepMode), .rdy(rdy), .halted(halted)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mState = 0; mRdy = 1'b1; mArm = 1'b0; mStepQ = 1'b0; mPh2Q = 1'b0;
    end else begin
      bit pulse, fall;
      pulse = stepReq && !mStepQ;
      fall  = mPh2Q && !ph2;
      if (!stepMode) begin
        mState = 0; mRdy = 1'b1;
      end else if (mState == 0) begin
        mState = 1; mArm = 1'b1;
      end else if (mState == 1) begin
        if (mArm && sync && !ph2) begin mState = 2; mRdy = 1'b0; end
        else if (fall) mArm = 1'b1;
      end else if (pulse) begin
        mState = 1; mRdy = 1'b1; mArm = 1'b0;
      end
      mStepQ = stepReq;
      mPh2Q  = ph2;
      started = 1'b1;
    end
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // per-clock comparison, away from the rising edge
  always @(negedge clk) begin
    if (started && rstN) begin
      check(rdy == mRdy, curReq, rdy, mRdy);
      check(halted == (mState == 2), "R8", halted, mState == 2);
    end
  end

  // bus generator: lengths 2,3,4 cycles per instruction, stalls while rdy low
  initial begin
    int len = 2;
    int pos = 0;
    wait (rstN);
    forever begin
      @(negedge clk);
      ph2 = 1'b0;
      sync = (pos == 0);
      repeat (2) @(negedge clk);
      while (!rdy) @(negedge clk);
      ph2 = 1'b1;
      repeat (2) @(negedge clk);
      pos++;
      if (pos >= len) begin
        pos = 0;
        len = (len == 4) ? 2 : len + 1;
      end
    end
  end

  task automatic waitHalt();
    while (!halted) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rdy == 1'b1, "R1", rdy, 1);
    check(halted == 1'b0, "R1", halted, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(rdy == 1'b1, "R1", rdy, 1);

    curReq = "R2";
    repeat (40) @(negedge clk);
    check(rdy == 1'b1, "R2", rdy, 1);

    curReq = "R3";
    stepMode = 1'b1;
    waitHalt();
    check(sync == 1'b1, "R3", sync, 1);
    check(ph2 == 1'b0, "R4", ph2, 0);
    repeat (20) @(negedge clk);
    check(rdy == 1'b0, "R5", rdy, 0);

    curReq = "R5";
    stepReq = 1'b1;
    @(negedge clk);
    check(rdy == 1'b1, "R5", rdy, 1);
    curReq = "R6";
    repeat (80) @(negedge clk);
    check(halted == 1'b1, "R6", halted, 1);
    check(sync == 1'b1, "R6", sync, 1);
    stepReq = 1'b0;
    repeat (5) @(negedge clk);

    for (int k = 0; k < 6; k++) begin
      curReq = "R5";
      stepReq = 1'b1;
      @(negedge clk);
      check(rdy == 1'b1, "R5", rdy, 1);
      stepReq = 1'b0;
      curReq = "R6";
      waitHalt();
      check(sync == 1'b1 && ph2 == 1'b0, "R6", {sync, ph2}, 2);
      repeat (3) @(negedge clk);
    end

    curReq = "R7";
    stepReq = 1'b1;
    @(negedge clk);
    stepReq = 1'b0;
    @(negedge clk);
    stepReq = 1'b1;
    @(negedge clk);
    check(rdy == 1'b1, "R7", rdy, 1);
    stepReq = 1'b0;
    waitHalt();
    repeat (30) @(negedge clk);
    check(halted == 1'b1, "R7", halted, 1);

    curReq = "R2";
    stepMode = 1'b0;
    @(negedge clk);
    check(rdy == 1'b1, "R2", rdy, 1);
    check(halted == 1'b0, "R2", halted, 0);
    repeat (30) @(negedge clk);

    for (int k = 0; k < 5; k++) begin
      curReq = "R3";
      stepMode = 1'b1;
      repeat (3 + k) @(negedge clk);
      waitHalt();
      check(sync == 1'b1, "R3", sync, 1);
      curReq = "R2";
      stepMode = 1'b0;
      @(negedge clk);
      check(rdy == 1'b1, "R2", rdy, 1);
      repeat (7 + k) @(negedge clk);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule